// File: doc/BRIEF.md
# Fixed-Priority Memory Cycle Arbiter

This block decides which of seven devices gets the next cycle of a shared global RAM. Each device has an active-low request line and an active-low grant line. A device pulls its request low once its address and data are ready. The arbiter passes the request lines through a synchronizer clocked by the memory clock. At every slot boundary it then picks one winner from the requesters that are eligible. It pulls that device's grant low, which enables the device's bus drivers, and raises the transceiver enable for as long as the grant lasts.

Priority is fixed. A feedback rule stops any device from taking two slots back to back. The floating-point processor is the one exception: it may repeat when nothing above it is requesting. If the lockout leaves no eligible device, the arbiter spends one idle slot with the transceivers disabled and clears its memory of the last winner. When no device requests at all, it stays idle with every grant high.

Top module: `gram_cycle_arbiter`

## Requirements
- R1: Requester index i uses req_n[i] and gnt_n[i], both active low. Priority runs from index 0 (highest) to index 6 (lowest): 0 FFT processor, 1 filter channel 1, 2 filter channel 2, 3 memory refresh, 4 display interface, 5 floating-point processor, 6 system CPU.
- R2: Every request passes through a two-flop synchronizer. From reset release with a request already low, the first grant is low at the third rising edge and not before.
- R3: At most one gnt_n bit is low at any time. xcvr_en is high exactly when some gnt_n bit is low.
- R4: A grant stays low for exactly HOLD_CLKS clocks. Between two grants there is at least one clock with all grants high, and the grant never moves directly from one device to another.
- R5: At each slot decision, the lowest-index eligible requester wins.
- R6: A device other than index 5 that won the previous slot is not eligible for the next slot.
- R7: Index 5 may win consecutive slots while no lower-index device requests. A requesting lower-index device that is not locked out wins over it.
- R8: If the lockout leaves no eligible requester, one idle slot of one clock follows, with all grants high. The lockout memory is then cleared and the next decision grants the locked device. The gap between the two grants is therefore two clocks instead of one.
- R9: With no request asserted, all grants stay high and xcvr_en stays low.
- R10: While rst is high, and on the first clock after it, all grants are high and xcvr_en is low, whatever the requests are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | N_REQ | Active-low memory requests, bit 0 highest priority |
| gnt_n | output | N_REQ | Active-low memory grants, registered |
| xcvr_en | output | 1 | Global bus transceiver enable, high while a grant is active |

## Verification
The bench builds the block with the default seven requesters, a two-stage synchronizer and HOLD_CLKS set to 3. With these values every one of the 128 constant request patterns can be swept in a few thousand clocks. For each pattern, four successive grants are checked for winner, hold length and gap. These sweeps reach every lockout case, every idle-slot case and the repeat exemption for index 5. A further run raises the highest-priority request while index 5 is repeating, which shows the hand-back between the two devices under the synchronizer delay.

// File: rtl/gram_arb_pkg.sv
package gram_arb_pkg;
  typedef enum logic {
    SEQ_ARB  = 1'b0,
    SEQ_HOLD = 1'b1
  } seq_state_t;
endpackage

// File: rtl/gram_req_sync.sv
module gram_req_sync #(
  parameter int N_REQ       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] req_n,
  output logic [N_REQ-1:0] req_act
);
  logic [N_REQ-1:0] stage_q [SYNC_STAGES];

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stage_q[s] <= '1;
        end else begin
          if (s == 0) stage_q[s] <= req_n;
          else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign req_act = ~stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/gram_prio_pick.sv
module gram_prio_pick #(
  parameter int N_REQ      = 7,
  parameter int REPEAT_IDX = 5,
  localparam int IDXW      = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic [N_REQ-1:0] req_act,
  input  logic             last_vld,
  input  logic [IDXW-1:0]  last_idx,
  output logic             win_vld,
  output logic [IDXW-1:0]  win_idx
);
  logic [N_REQ-1:0] above_busy;
  logic [N_REQ-1:0] elig;

  genvar i;
  generate
    for (i = 0; i < N_REQ; i++) begin : g_elig
      if (i == 0) begin : g_top
        assign above_busy[i] = 1'b0;
      end else begin : g_rest
        assign above_busy[i] = |req_act[i-1:0];
      end
      if (i == REPEAT_IDX) begin : g_rep
        assign elig[i] = req_act[i] &
                         (!(last_vld && (last_idx == IDXW'(i))) || !above_busy[i]);
      end else begin : g_lock
        assign elig[i] = req_act[i] & !(last_vld && (last_idx == IDXW'(i)));
      end
    end
  endgenerate

  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    for (int k = N_REQ-1; k >= 0; k--) begin
      if (elig[k]) begin
        win_vld = 1'b1;
        win_idx = IDXW'(k);
      end
    end
  end
endmodule

// File: rtl/gram_grant_seq.sv
module gram_grant_seq
  import gram_arb_pkg::*;
#(
  parameter int N_REQ     = 7,
  parameter int HOLD_CLKS = 4,
  localparam int IDXW     = (N_REQ > 1) ? $clog2(N_REQ) : 1,
  localparam int CNTW     = $clog2(HOLD_CLKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_vld,
  input  logic [IDXW-1:0]  win_idx,
  output logic [N_REQ-1:0] gnt_n,
  output logic             xcvr_en,
  output logic             last_vld,
  output logic [IDXW-1:0]  last_idx
);
  seq_state_t      state_q;
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SEQ_ARB;
      cnt_q    <= '0;
      gnt_n    <= '1;
      xcvr_en  <= 1'b0;
      last_vld <= 1'b0;
      last_idx <= '0;
    end else begin
      case (state_q)
        SEQ_ARB: begin
          if (win_vld) begin
            gnt_n    <= ~(N_REQ'(1) << win_idx);
            xcvr_en  <= 1'b1;
            last_idx <= win_idx;
            last_vld <= 1'b1;
            cnt_q    <= CNTW'(HOLD_CLKS - 1);
            state_q  <= SEQ_HOLD;
          end else begin
            last_vld <= 1'b0;
          end
        end
        default: begin
          if (cnt_q == '0) begin
            gnt_n   <= '1;
            xcvr_en <= 1'b0;
            state_q <= SEQ_ARB;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/gram_cycle_arbiter.sv
module gram_cycle_arbiter #(
  parameter int N_REQ       = 7,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CLKS   = 4,
  parameter int REPEAT_IDX  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] req_n,
  output logic [N_REQ-1:0] gnt_n,
  output logic             xcvr_en
);
  localparam int IDXW = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  logic [N_REQ-1:0] req_act;
  logic             win_vld;
  logic [IDXW-1:0]  win_idx;
  logic             last_vld;
  logic [IDXW-1:0]  last_idx;

  gram_req_sync #(.N_REQ(N_REQ), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .req_n(req_n), .req_act(req_act)
  );

  gram_prio_pick #(.N_REQ(N_REQ), .REPEAT_IDX(REPEAT_IDX)) u_pick (
    .req_act(req_act), .last_vld(last_vld), .last_idx(last_idx),
    .win_vld(win_vld), .win_idx(win_idx)
  );

  gram_grant_seq #(.N_REQ(N_REQ), .HOLD_CLKS(HOLD_CLKS)) u_seq (
    .clk(clk), .rst(rst), .win_vld(win_vld), .win_idx(win_idx),
    .gnt_n(gnt_n), .xcvr_en(xcvr_en), .last_vld(last_vld), .last_idx(last_idx)
  );
endmodule

// File: rtl/gram_cycle_arbiter_chk.sv
module gram_cycle_arbiter_chk #(
  parameter int N_REQ      = 7,
  parameter int HOLD_CLKS  = 4,
  parameter int REPEAT_IDX = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [N_REQ-1:0] gnt_n,
  input logic             xcvr_en
);
  logic any_gnt;
  logic prev_any;
  logic rst_q;
  int   run_q;
  int   gap_q;
  int   last_q;
  logic last_ok;
  int   cur_idx;
  logic start;

  assign any_gnt = |(~gnt_n);
  assign start   = any_gnt && !prev_any;

  always_comb begin
    cur_idx = -1;
    for (int k = 0; k < N_REQ; k++) if (!gnt_n[k]) cur_idx = k;
  end

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      prev_any <= 1'b0;
      run_q    <= 0;
      gap_q    <= 0;
      last_q   <= -1;
      last_ok  <= 1'b0;
    end else begin
      prev_any <= any_gnt;
      run_q    <= any_gnt ? run_q + 1 : 0;
      gap_q    <= any_gnt ? 0 : gap_q + 1;
      if (start) begin
        last_q  <= cur_idx;
        last_ok <= 1'b1;
      end
    end
    // R10
    if (rst_q && !rst) begin
      reset_state_chk: assert ((&gnt_n) && !xcvr_en);
    end
  end

  // R3
  one_grant_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(~gnt_n));
  // R3
  xcvr_match_chk: assert property (@(posedge clk) disable iff (rst) xcvr_en == any_gnt);
  // R4
  no_handover_chk: assert property (@(posedge clk) disable iff (rst)
    any_gnt |=> (!any_gnt || (gnt_n == $past(gnt_n))));
  // R4
  hold_len_chk: assert property (@(posedge clk) disable iff (rst)
    (!any_gnt && prev_any) |-> (run_q == HOLD_CLKS));
  // R6
  lockout_chk: assert property (@(posedge clk) disable iff (rst)
    (start && last_ok && gap_q == 1) |-> (cur_idx != last_q || cur_idx == REPEAT_IDX));
endmodule

bind gram_cycle_arbiter gram_cycle_arbiter_chk #(
  .N_REQ(N_REQ), .HOLD_CLKS(HOLD_CLKS), .REPEAT_IDX(REPEAT_IDX)
) u_chk (
  .clk(clk), .rst(rst), .gnt_n(gnt_n), .xcvr_en(xcvr_en)
);

// File: tb/gram_cycle_arbiter_bench.sv
module gram_cycle_arbiter_bench;
  localparam int N   = 7;
  localparam int G   = 3;
  localparam int REP = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req_n = '1;
  logic [N-1:0] gnt_n;
  logic         xcvr_en;

  int errors = 0;
  int checks = 0;

  always #5ns clk = ~clk;

  gram_cycle_arbiter #(.N_REQ(N), .SYNC_STAGES(2), .HOLD_CLKS(G), .REPEAT_IDX(REP))
    u_gram_cycle_arbiter (.clk(clk), .rst(rst), .req_n(req_n), .gnt_n(gnt_n), .xcvr_en(xcvr_en));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pick(input int pat, input int last);
    for (int i = 0; i < N; i++) begin
      if (pat[i] && (i != last || (i == REP && (pat & ((1 << i) - 1)) == 0))) return i;
    end
    return -1;
  endfunction

  function automatic int gidx(input logic [N-1:0] g);
    int r = -1;
    for (int k = 0; k < N; k++) if (!g[k]) r = k;
    return r;
  endfunction

  task automatic check_outputs();
    int cnt = 0;
    for (int k = 0; k < N; k++) if (!gnt_n[k]) cnt++;
    chk(cnt <= 1, "R3 grant count", cnt, 1);
    chk(xcvr_en == (cnt != 0), "R3 xcvr_en", int'(xcvr_en), int'(cnt != 0));
  endtask

  task automatic do_reset(input logic [N-1:0] rq);
    rst   = 1'b1;
    req_n = rq;
    repeat (3) begin
      @(negedge clk);
      chk(gnt_n == '1, "R10 grants in reset", int'(gnt_n), (1 << N) - 1);
      chk(!xcvr_en, "R10 xcvr in reset", int'(xcvr_en), 0);
    end
  endtask

  task automatic next_grant(output int idx, output int len, output int gap);
    gap = 1; idx = -1; len = 0;
    forever begin
      @(negedge clk);
      check_outputs();
      if (gnt_n != '1) break;
      gap++;
      if (gap > 40) return;
    end
    idx = gidx(gnt_n);
    len = 1;
    forever begin
      @(negedge clk);
      check_outputs();
      if (gnt_n == '1) break;
      chk(gidx(gnt_n) == idx, "R4 grant moved", gidx(gnt_n), idx);
      len++;
      if (len > 40) break;
    end
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int idx, len, gap, last, w, eg;
    // R10: requests asserted during reset must not produce grants
    do_reset('0);
    rst = 1'b0;
    req_n = '1;
    @(negedge clk);
    chk(gnt_n == '1 && !xcvr_en, "R10 first cycle after reset", int'(gnt_n), (1 << N) - 1);

    // R9: no requests
    do_reset('1);
    rst = 1'b0;
    repeat (20) begin
      @(negedge clk);
      chk(gnt_n == '1, "R9 idle grants", int'(gnt_n), (1 << N) - 1);
      chk(!xcvr_en, "R9 idle xcvr", int'(xcvr_en), 0);
    end

    // R1 R5 R6 R7 R8 R2 R4: sweep every constant request pattern
    for (int p = 1; p < (1 << N); p++) begin
      do_reset('1);
      rst   = 1'b0;
      req_n = ~N'(p);
      last  = -1;
      for (int ev = 0; ev < 4; ev++) begin
        eg = (ev == 0) ? 3 : 1;
        w  = pick(p, last);
        if (w < 0) begin
          last = -1;
          eg++;
          w = pick(p, last);
        end
        next_grant(idx, len, gap);
        chk(idx == w, "R1 R5 R6 R7 winner", idx, w);
        chk(len == G, "R4 hold length", len, G);
        if (ev == 0)      chk(gap == eg, "R2 sync latency", gap, eg);
        else if (eg == 2) chk(gap == eg, "R8 idle slot gap", gap, eg);
        else              chk(gap == eg, "R4 gap between grants", gap, eg);
        last = w;
      end
    end

    // R7: index 5 repeating, then index 0 joins
    do_reset('1);
    rst   = 1'b0;
    req_n = ~N'(1 << REP);
    next_grant(idx, len, gap);
    chk(idx == REP, "R7 first FPP grant", idx, REP);
    next_grant(idx, len, gap);
    chk(idx == REP && gap == 1, "R7 FPP repeat", idx, REP);
    req_n[0] = 1'b0;
    next_grant(idx, len, gap);
    chk(idx == REP, "R2 R7 FFT not yet synchronized", idx, REP);
    next_grant(idx, len, gap);
    chk(idx == 0, "R7 higher priority beats FPP", idx, 0);
    next_grant(idx, len, gap);
    chk(idx == REP, "R6 R7 FFT locked, FPP wins", idx, REP);
    next_grant(idx, len, gap);
    chk(idx == 0, "R5 FFT again", idx, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule